// File: doc/BRIEF.md
# Privileged Interrupt Arbitration Unit

This block selects the single interrupt a hart should take next. It combines sticky pending state with an enable vector and a global mask. The pending state is fed by local interrupt pins and by software post, clear and clear-all operations. The global mask is derived from the current privilege mode, the per-mode global enable bits and the machine and supervisor delegation masks.

From the surviving candidates it chooses one by a fixed priority. The local interrupts (causes 16 to 63) come first, the highest-numbered one winning. The standard machine, supervisor and user interrupts follow. A non-maskable request overrides everything.

The arbitration path is combinational from the registered pending, enable and NMI state and from the mode inputs. A trap-entry stage can therefore sample the result in the same cycle the mode changes. Cause codes follow the standard bit layout: user software 0, supervisor software 1, machine software 3, user timer 4, supervisor timer 5, machine timer 7, user external 8, supervisor external 9, machine external 11, and local n at 16+n. Privilege encodings are U = 0, S = 1 and M = 3.

Top module: `irq_arb_top`

## Requirements
- R1: After reset, the pending vector, the enable vector and the NMI request are all zero, so `take_irq`, `take_nmi` and `take_cause` are all 0.
- R2: A maskable cause is a candidate only when its pending bit, its enable bit and its global mask bit are all set. With no candidate and no NMI, `take_irq` is 0 and `take_cause` is 0.
- R3: Any local candidate (cause 16 or higher) beats every standard candidate, and among local candidates the highest cause number wins.
- R4: Among standard candidates the order is, from first to last: 11, 3, 7, 9, 1, 5, 8, 0, 4.
- R5: A pending NMI makes `take_irq` and `take_nmi` 1 and `take_cause` 0, regardless of mode, enables or other pending bits.
- R6: In M-mode (`priv_mode` = 3) the local and machine causes are unmasked exactly when `mie_g` is 1. Supervisor and user causes are always masked.
- R7: In S-mode (`priv_mode` = 1), local and machine causes whose `mdeleg` bit is 0 are unmasked. Causes with the `mdeleg` bit set, and the supervisor causes, are unmasked only when `sie_g` is 1. User causes are masked.
- R8: In U-mode (`priv_mode` = 0) with `s_present` = 1, local, machine and supervisor causes with a clear `sdeleg` bit are unmasked, and those with the bit set need `uie_g`. User causes need `uie_g` in every U-mode case.
- R9: In U-mode with `s_present` = 0, `mdeleg` takes the place of `sdeleg` for local and machine causes, and the supervisor causes are masked.
- R10: With `wide_rv64` = 0, causes 32 to 63 never take part in selection, even when pending, enabled and unmasked.
- R11: A high level on `lcl_pins[n]` at a clock edge sets pending cause 16+n. `post_valid` sets pending cause `post_idx` and `clear_valid` clears pending cause `clear_idx`. `clear_all` zeroes every pending bit and the NMI request.
- R12: The unused cause positions 2, 6, 10 and 12 to 15 can never become pending or enabled, so posting them never leads to a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcl_pins | input | 48 | Local interrupt request pins, pin n maps to cause 16+n |
| post_valid | input | 1 | Set one pending bit |
| post_idx | input | 6 | Cause index to set |
| clear_valid | input | 1 | Clear one pending bit |
| clear_idx | input | 6 | Cause index to clear |
| clear_all | input | 1 | Zero all pending bits and the NMI request |
| en_we | input | 1 | Load the enable vector |
| en_wdata | input | 64 | New enable vector |
| nmi_post | input | 1 | Raise the NMI request |
| nmi_clear | input | 1 | Drop the NMI request |
| priv_mode | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| mie_g | input | 1 | Machine global enable |
| sie_g | input | 1 | Supervisor global enable |
| uie_g | input | 1 | User global enable |
| s_present | input | 1 | Supervisor mode implemented |
| wide_rv64 | input | 1 | 1 for 64-bit width, 0 for 32-bit width |
| mdeleg | input | 64 | Machine delegation mask |
| sdeleg | input | 64 | Supervisor delegation mask |
| take_irq | output | 1 | An interrupt (maskable or NMI) should be taken |
| take_nmi | output | 1 | The interrupt to take is the NMI |
| take_cause | output | 6 | Cause code of the selected maskable interrupt |

## Verification
Operations on pending, enable or NMI state show up at the outputs one rising edge after they are driven. Mode, global-enable, delegation and width inputs reach the outputs combinationally in the same cycle. The bench drives every input on a falling edge. It loads state over as many edges as needed, then samples the outputs on the next falling edge, after the last register load and with the mode inputs settled. Each vector starts with a clear-all cycle, so no pending state carries over from one vector to the next.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  localparam int unsigned LOCAL_BASE  = 16;
  localparam int unsigned DEF_N_LOCAL = 48;
  localparam int unsigned NARROW_W    = 32;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam int unsigned C_USI = 0;
  localparam int unsigned C_SSI = 1;
  localparam int unsigned C_MSI = 3;
  localparam int unsigned C_UTI = 4;
  localparam int unsigned C_STI = 5;
  localparam int unsigned C_MTI = 7;
  localparam int unsigned C_UEI = 8;
  localparam int unsigned C_SEI = 9;
  localparam int unsigned C_MEI = 11;

  localparam logic [63:0] GRP_USER = (64'd1 << C_USI) | (64'd1 << C_UTI) | (64'd1 << C_UEI);
  localparam logic [63:0] GRP_SUP  = (64'd1 << C_SSI) | (64'd1 << C_STI) | (64'd1 << C_SEI);
  localparam logic [63:0] GRP_MACH = (64'd1 << C_MSI) | (64'd1 << C_MTI) | (64'd1 << C_MEI);

  // standard causes, highest priority first
  localparam int unsigned N_STD = 9;
  localparam logic [5:0] STD_RANK [N_STD] = '{
    6'(C_MEI), 6'(C_MSI), 6'(C_MTI),
    6'(C_SEI), 6'(C_SSI), 6'(C_STI),
    6'(C_UEI), 6'(C_USI), 6'(C_UTI)
  };

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_sel_pkg::*;
#(
  parameter int unsigned N_LOCAL = DEF_N_LOCAL,
  parameter int unsigned VEC_W   = LOCAL_BASE + N_LOCAL,
  parameter int unsigned CAUSE_W = $clog2(VEC_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LOCAL-1:0] lcl_pins,
  input  logic               post_valid,
  input  logic [CAUSE_W-1:0] post_idx,
  input  logic               clear_valid,
  input  logic [CAUSE_W-1:0] clear_idx,
  input  logic               clear_all,
  input  logic               en_we,
  input  logic [VEC_W-1:0]   en_wdata,
  input  logic               nmi_post,
  input  logic               nmi_clear,
  output logic [VEC_W-1:0]   pend_q,
  output logic [VEC_W-1:0]   en_q,
  output logic               nmi_q
);

  localparam logic [VEC_W-1:0] LCL_MASK = {{N_LOCAL{1'b1}}, {LOCAL_BASE{1'b0}}};
  localparam logic [VEC_W-1:0] IMPL     = LCL_MASK | VEC_W'(GRP_USER | GRP_SUP | GRP_MACH);

  logic [VEC_W-1:0] set_vec, clr_vec, pend_d, en_d;
  logic             pend_upd, nmi_upd, nmi_d;

  always_comb begin
    set_vec  = {lcl_pins, {LOCAL_BASE{1'b0}}};
    if (post_valid) set_vec = set_vec | (VEC_W'(1) << post_idx);
    clr_vec  = '0;
    if (clear_valid) clr_vec = VEC_W'(1) << clear_idx;
    pend_upd = clear_all | (|set_vec) | clear_valid;
    if (clear_all) pend_d = '0;
    else           pend_d = ((pend_q | set_vec) & ~clr_vec) & IMPL;
    en_d     = en_wdata & IMPL;
    nmi_upd  = clear_all | nmi_clear | nmi_post;
    nmi_d    = ~(clear_all | nmi_clear) & nmi_post;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      nmi_q  <= 1'b0;
    end else begin
      if (pend_upd) pend_q <= pend_d;
      if (en_we)    en_q   <= en_d;
      if (nmi_upd)  nmi_q  <= nmi_d;
    end
  end

  p_clear_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (pend_q == '0) && !nmi_q);

  p_pin_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_all && !clear_valid) |=>
      ((pend_q[VEC_W-1:LOCAL_BASE] & $past(lcl_pins)) == $past(lcl_pins)));

  p_post_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && !clear_all && !clear_valid && IMPL[post_idx]) |=> pend_q[$past(post_idx)]);

  p_unimpl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~IMPL) == '0) && ((en_q & ~IMPL) == '0));

endmodule

// File: rtl/irq_mode_mask.sv
module irq_mode_mask
  import irq_sel_pkg::*;
#(
  parameter int unsigned N_LOCAL = DEF_N_LOCAL,
  parameter int unsigned VEC_W   = LOCAL_BASE + N_LOCAL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  priv_e            priv,
  input  logic             mie_g,
  input  logic             sie_g,
  input  logic             uie_g,
  input  logic             s_present,
  input  logic [VEC_W-1:0] mdeleg,
  input  logic [VEC_W-1:0] sdeleg,
  output logic [VEC_W-1:0] gmask
);

  localparam logic [VEC_W-1:0] M_L = {{N_LOCAL{1'b1}}, {LOCAL_BASE{1'b0}}};
  localparam logic [VEC_W-1:0] M_M = VEC_W'(GRP_MACH);
  localparam logic [VEC_W-1:0] M_S = VEC_W'(GRP_SUP);
  localparam logic [VEC_W-1:0] M_U = VEC_W'(GRP_USER);
  localparam logic [VEC_W-1:0] M_LM  = M_L | M_M;
  localparam logic [VEC_W-1:0] M_LMS = M_L | M_M | M_S;

  logic [VEC_W-1:0] u_deleg, u_scope;

  always_comb begin
    // in U-mode the governing delegation mask depends on S-mode presence
    u_deleg = s_present ? sdeleg : mdeleg;
    u_scope = s_present ? M_LMS  : M_LM;
    gmask   = '0;
    unique case (priv)
      PRIV_M: begin
        if (mie_g) gmask = M_LM;
      end
      PRIV_S: begin
        gmask = M_LM & ~mdeleg;
        if (sie_g) gmask = gmask | (M_LM & mdeleg) | M_S;
      end
      PRIV_U: begin
        gmask = u_scope & ~u_deleg;
        if (uie_g) gmask = gmask | (u_scope & u_deleg) | M_U;
      end
      default: gmask = '0;
    endcase
  end

  p_m_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_M) |-> ((gmask & (M_S | M_U)) == '0) && ((gmask == '0) == !mie_g));

  p_s_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_S) |-> ((gmask & M_U) == '0) && ((gmask & M_LM & ~mdeleg) == (M_LM & ~mdeleg)));

  p_u_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_U && !uie_g) |-> ((gmask & M_U) == '0));

  p_u_no_s_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_U && !s_present) |-> ((gmask & M_S) == '0));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_sel_pkg::*;
#(
  parameter int unsigned N_LOCAL = DEF_N_LOCAL,
  parameter int unsigned VEC_W   = LOCAL_BASE + N_LOCAL,
  parameter int unsigned CAUSE_W = $clog2(VEC_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VEC_W-1:0]   cand,
  input  logic               wide_rv64,
  output logic               valid,
  output logic [CAUSE_W-1:0] cause
);

  localparam logic [VEC_W-1:0] NARROW_KEEP = VEC_W'({NARROW_W{1'b1}});

  logic [VEC_W-1:0] cand_w;

  always_comb begin
    cand_w = wide_rv64 ? cand : (cand & NARROW_KEEP);
    valid  = |cand_w;
    cause  = '0;
    // lowest-ranked standard first, so higher rank overwrites
    for (int k = N_STD - 1; k >= 0; k--) begin
      if (cand_w[STD_RANK[k]]) cause = CAUSE_W'(STD_RANK[k]);
    end
    // locals outrank standard; ascending scan leaves the highest
    for (int i = LOCAL_BASE; i < VEC_W; i++) begin
      if (cand_w[i]) cause = CAUSE_W'(i);
    end
  end

  p_pick_is_cand_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> cand[cause]);

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (cause == '0));

  p_local_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (|cand_w[VEC_W-1:LOCAL_BASE])) |-> (cause >= CAUSE_W'(LOCAL_BASE)));

  p_narrow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !wide_rv64) |-> (int'(cause) < NARROW_W));

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_sel_pkg::*;
#(
  parameter int unsigned N_LOCAL = DEF_N_LOCAL,
  localparam int unsigned VEC_W  = LOCAL_BASE + N_LOCAL,
  localparam int unsigned CAUSE_W = $clog2(VEC_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LOCAL-1:0] lcl_pins,
  input  logic               post_valid,
  input  logic [CAUSE_W-1:0] post_idx,
  input  logic               clear_valid,
  input  logic [CAUSE_W-1:0] clear_idx,
  input  logic               clear_all,
  input  logic               en_we,
  input  logic [VEC_W-1:0]   en_wdata,
  input  logic               nmi_post,
  input  logic               nmi_clear,
  input  logic [1:0]         priv_mode,
  input  logic               mie_g,
  input  logic               sie_g,
  input  logic               uie_g,
  input  logic               s_present,
  input  logic               wide_rv64,
  input  logic [VEC_W-1:0]   mdeleg,
  input  logic [VEC_W-1:0]   sdeleg,
  output logic               take_irq,
  output logic               take_nmi,
  output logic [CAUSE_W-1:0] take_cause
);

  logic [VEC_W-1:0]   pend_q, en_q, gmask, cand;
  logic               nmi_q, pick_valid;
  logic [CAUSE_W-1:0] pick_cause;

  irq_pend_bank #(.N_LOCAL(N_LOCAL), .VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) u_bank (
    .clk, .rst_n, .lcl_pins, .post_valid, .post_idx, .clear_valid, .clear_idx,
    .clear_all, .en_we, .en_wdata, .nmi_post, .nmi_clear,
    .pend_q, .en_q, .nmi_q
  );

  irq_mode_mask #(.N_LOCAL(N_LOCAL), .VEC_W(VEC_W)) u_mask (
    .clk, .rst_n, .priv(priv_e'(priv_mode)), .mie_g, .sie_g, .uie_g,
    .s_present, .mdeleg, .sdeleg, .gmask
  );

  assign cand = pend_q & en_q & gmask;

  irq_prio_pick #(.N_LOCAL(N_LOCAL), .VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) u_pick (
    .clk, .rst_n, .cand, .wide_rv64, .valid(pick_valid), .cause(pick_cause)
  );

  always_comb begin
    take_nmi   = nmi_q;
    take_irq   = nmi_q | pick_valid;
    take_cause = nmi_q ? '0 : pick_cause;
  end

  p_nmi_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> take_irq && (take_cause == '0));

  p_take_needs_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (nmi_q || ((pend_q & en_q) != '0)));

endmodule

// File: tb/test_irq_arb_top.sv
module test_irq_arb_top;

  localparam int NV = 20;
  localparam int TW = 270;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] lcl_pins;
  logic        post_valid, clear_valid, clear_all, en_we, nmi_post, nmi_clear;
  logic [5:0]  post_idx, clear_idx;
  logic [63:0] en_wdata, mdeleg, sdeleg;
  logic [1:0]  priv_mode;
  logic        mie_g, sie_g, uie_g, s_present, wide_rv64;
  logic        take_irq, take_nmi;
  logic [5:0]  take_cause;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_arb_top i_irq_arb_top (
    .clk, .rst_n, .lcl_pins, .post_valid, .post_idx, .clear_valid, .clear_idx,
    .clear_all, .en_we, .en_wdata, .nmi_post, .nmi_clear, .priv_mode,
    .mie_g, .sie_g, .uie_g, .s_present, .wide_rv64, .mdeleg, .sdeleg,
    .take_irq, .take_nmi, .take_cause
  );

  // {priv, mie, sie, uie, s_present, rv64, mdeleg, sdeleg, pend, en, take, cause}
  localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [TW-1:0] TBL [NV] = '{
    {2'd3, 5'b10001, 64'h0, 64'h0, 64'h888, ALL, 1'b1, 6'd11},                      // R4
    {2'd3, 5'b10001, 64'h0, 64'h0, 64'h88, ALL, 1'b1, 6'd3},                        // R4
    {2'd3, 5'b10001, 64'h0, 64'h0, 64'h80, ALL, 1'b1, 6'd7},                        // R4
    {2'd3, 5'b10001, 64'h0, 64'h0, 64'h200, ALL, 1'b0, 6'd0},                       // R6
    {2'd3, 5'b00001, 64'h0, 64'h0, 64'h10800, ALL, 1'b0, 6'd0},                     // R6
    {2'd3, 5'b10001, 64'h0, 64'h0, 64'h8000_0000_0001_0800, ALL, 1'b1, 6'd63},      // R3
    {2'd3, 5'b10000, 64'h0, 64'h0, 64'h8000_0000_8000_0800, ALL, 1'b1, 6'd31},      // R10
    {2'd3, 5'b10000, 64'h0, 64'h0, 64'h0100_0000_0000_0080, ALL, 1'b1, 6'd7},       // R10
    {2'd1, 5'b00001, 64'h0, 64'h0, 64'h280, ALL, 1'b1, 6'd7},                       // R7
    {2'd1, 5'b00001, 64'h80, 64'h0, 64'h82, ALL, 1'b0, 6'd0},                       // R7
    {2'd1, 5'b01001, 64'h80, 64'h0, 64'h320, ALL, 1'b1, 6'd9},                      // R7
    {2'd1, 5'b01001, 64'h0, 64'h0, 64'h101, ALL, 1'b0, 6'd0},                       // R7
    {2'd0, 5'b00011, 64'h0, 64'h800, 64'hA00, ALL, 1'b1, 6'd9},                     // R8
    {2'd0, 5'b00111, 64'h0, 64'h800, 64'h810, ALL, 1'b1, 6'd11},                    // R8
    {2'd0, 5'b00011, 64'h0, 64'h0, 64'h10, ALL, 1'b0, 6'd0},                        // R8
    {2'd0, 5'b00001, 64'h20_0000, 64'h0, 64'h20_0200, ALL, 1'b0, 6'd0},             // R9
    {2'd0, 5'b00101, 64'h20_0000, 64'h0, 64'h20_0200, ALL, 1'b1, 6'd21},            // R9
    {2'd3, 5'b10001, 64'h0, 64'h0, 64'h808, 64'h8, 1'b1, 6'd3},                     // R2
    {2'd3, 5'b10001, 64'h0, 64'h0, 64'h800, 64'h0, 1'b0, 6'd0},                     // R2
    {2'd0, 5'b00011, 64'h0, 64'h0, 64'h1_0100, ALL, 1'b1, 6'd16}                    // R8
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input int t, input int n, input int c);
    check(req, "take_irq", int'(take_irq), t);
    check(req, "take_nmi", int'(take_nmi), n);
    check(req, "take_cause", int'(take_cause), c);
  endtask

  task automatic idle_inputs();
    lcl_pins = '0; post_valid = 0; post_idx = '0; clear_valid = 0; clear_idx = '0;
    clear_all = 0; en_we = 0; en_wdata = '0; nmi_post = 0; nmi_clear = 0;
  endtask

  task automatic pulse_clear_all();
    @(negedge clk); clear_all = 1;
    @(negedge clk); clear_all = 0;
  endtask

  task automatic post(input int idx);
    @(negedge clk); post_valid = 1; post_idx = 6'(idx);
    @(negedge clk); post_valid = 0;
  endtask

  task automatic write_en(input logic [63:0] v);
    @(negedge clk); en_we = 1; en_wdata = v;
    @(negedge clk); en_we = 0;
  endtask

  task automatic set_mode(input logic [1:0] p, input logic [4:0] f);
    priv_mode = p; mie_g = f[4]; sie_g = f[3]; uie_g = f[2]; s_present = f[1]; wide_rv64 = f[0];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    set_mode(2'd3, 5'b10001);
    mdeleg = '0; sdeleg = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    outs("R1", 0, 0, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [TW-1:0] e;
      e = TBL[v];
      pulse_clear_all();
      set_mode(e[269:268], e[267:263]);
      mdeleg = e[262:199];
      sdeleg = e[198:135];
      write_en(e[70:7]);
      for (int b = 0; b < 64; b++) if (e[71 + b]) post(b);
      @(negedge clk);
      check($sformatf("vector%0d", v), "take_irq", int'(take_irq), int'(e[6]));
      check($sformatf("vector%0d", v), "take_cause", int'(take_cause), int'(e[5:0]));
      check($sformatf("vector%0d", v), "take_nmi", int'(take_nmi), 0);
    end

    // R11: pin n sets cause 16+n, clear removes it
    pulse_clear_all();
    set_mode(2'd3, 5'b10001); mdeleg = '0; sdeleg = '0;
    write_en(ALL);
    @(negedge clk); lcl_pins[3] = 1'b1;
    @(negedge clk); lcl_pins[3] = 1'b0;
    outs("R11 pin", 1, 0, 19);
    @(negedge clk); clear_valid = 1; clear_idx = 6'd19;
    @(negedge clk); clear_valid = 0;
    outs("R11 clear", 0, 0, 0);

    // R5: NMI wins over enabled local and ignores mode gating
    post(40);
    @(negedge clk); nmi_post = 1;
    @(negedge clk); nmi_post = 0;
    outs("R5 over local", 1, 1, 0);
    set_mode(2'd3, 5'b00001);
    write_en('0);
    @(negedge clk);
    outs("R5 masked", 1, 1, 0);
    @(negedge clk); nmi_clear = 1;
    @(negedge clk); nmi_clear = 0;
    outs("R5 dropped", 0, 0, 0);

    // R11: clear_all zeroes pending and NMI
    set_mode(2'd3, 5'b10001);
    write_en(ALL);
    post(11);
    @(negedge clk); nmi_post = 1;
    @(negedge clk); nmi_post = 0;
    outs("R11 before clear_all", 1, 1, 0);
    pulse_clear_all();
    outs("R11 after clear_all", 0, 0, 0);

    // R12: unused positions never pend
    post(2); post(6); post(10); post(14);
    @(negedge clk);
    outs("R12", 0, 0, 0);

    // R10 boundary: a narrow width hides cause 32 but not cause 31
    pulse_clear_all();
    set_mode(2'd3, 5'b10000);
    post(32);
    @(negedge clk);
    outs("R10 cause32 hidden", 0, 0, 0);
    post(31);
    outs("R10 cause31 kept", 1, 0, 31);
    wide_rv64 = 1'b1;
    @(negedge clk);
    outs("R10 wide sees 32", 1, 0, 32);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule